// File: doc/BRIEF.md
# Interrupt-Triggered DMA Request Dispatcher

This block sits between the peripheral interrupt sources and a DMA transfer engine. It decides, for each incoming interrupt request, whether a DMA channel serves it or the CPU receives it. Each of the sixteen channels holds an 8-bit selector with the interrupt number that triggers it. Each channel also has an enable bit and a stop-enable bit, and it keeps two sticky flags. The end flag records that the channel finished or was halted. The stop flag records that a receiver peripheral aborted the transfer.

A request goes to a channel only when three things are true in the same cycle: the selector equals the request number, the channel is enabled, and its end flag is clear. If any of these fails, the request falls through to the CPU. A channel therefore keeps taking requests until its last transfer completes. After that its source interrupt reaches the CPU. Software clears the flags, and a cyclic source then arms the channel again.

Top module: `dma_irq_dispatch`

## Requirements
- R1: After reset, the enable, stop-enable, end-flag and stop-flag registers are all zero, and neither `start_o` nor `cpu_irq_o` is asserted.
- R2: When `irq_valid_i` is high and a channel has a selector equal to `irq_num_i`, its enable bit set and its end flag clear, `start_o` is high in the next cycle and `start_ch_o` holds that channel's index.
- R3: A valid request that matches no enabled channel, or only disabled ones, raises `cpu_irq_o` in the next cycle, and `cpu_irq_num_o` carries the request number.
- R4: A channel whose end flag is set never takes a request. The request goes to another eligible channel or, if there is none, to the CPU.
- R5: When several channels are eligible for one request, the one with the lowest index is started.
- R6: A pulse on bit n of `done_i` sets bit n of `end_flags_o` at the next edge.
- R7: A write to the end-flag register (`cfg_reg_i`=1) or the stop-flag register (`cfg_reg_i`=2) clears each bit written as 0 and leaves each bit written as 1 unchanged. Writing 0x0000 clears all bits. Other codes: 0 writes the enable mask, 3 writes the stop-enable mask, and 4 writes the low 8 bits as the selector of channel `cfg_ch_i`.
- R8: `stop_req_i` with `stop_src_i` equal to the selector of an enabled channel that has a clear end flag and its stop-enable bit set sets both that channel's stop flag and its end flag. If the stop-enable bit is clear, both flags stay unchanged.
- R9: When a hardware set event and a software clear hit the same flag bit in the same cycle, the bit ends up set.
- R10: Once software clears a channel's end flag while the channel stays enabled, the next matching request starts it again.
- R11: Each valid request produces exactly one of `start_o` and `cpu_irq_o` in the following cycle. Without a valid request, neither is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_reg_i | input | 3 | Register code: 0 enable, 1 end flags, 2 stop flags, 3 stop enable, 4 selector |
| cfg_ch_i | input | 4 | Channel addressed by a selector write |
| cfg_wdata_i | input | 16 | Write data |
| irq_valid_i | input | 1 | Interrupt request strobe |
| irq_num_i | input | 8 | Interrupt request number |
| stop_req_i | input | 1 | Abort request from the receiver peripheral |
| stop_src_i | input | 8 | Interrupt number of the peripheral issuing the abort |
| done_i | input | 16 | Per-channel transfer completion pulses |
| start_o | output | 1 | Channel start strobe |
| start_ch_o | output | 4 | Index of the started channel |
| cpu_irq_o | output | 1 | Request forwarded to the CPU |
| cpu_irq_num_o | output | 8 | Number of the forwarded request |
| end_flags_o | output | 16 | End-flag register read data |
| enable_o | output | 16 | Enable register read data |
| stop_flags_o | output | 16 | Stop-flag register read data |

## Verification
The bench targets the following cases:
- Two channels sharing one selector, to expose a wrong winner picked by a reversed priority encoder.
- A channel whose end flag is set while the same number is requested. A design that ignored the flag would keep starting a finished channel and never forward the interrupt.
- A write of 1 bits to the flag registers, which a design treating writes as plain loads would use to set flags wrongly.
- A completion or abort landing in the same cycle as a clearing write. A design that let the clear win would lose the event.
- A stop request to a channel with stop-enable clear. Such a request must change neither flag.

// File: rtl/dma_disp_pkg.sv
`timescale 1ns/1ps
package dma_disp_pkg;
  localparam int unsigned NUM_CH_DEF = 16;
  localparam int unsigned IRQ_W_DEF  = 8;

  typedef enum logic [2:0] {
    REG_EN  = 3'd0,
    REG_END = 3'd1,
    REG_STP = 3'd2,
    REG_SEN = 3'd3,
    REG_SEL = 3'd4
  } cfg_reg_e;
endpackage

// File: rtl/dma_disp_chan.sv
`timescale 1ns/1ps
module dma_disp_chan #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [IRQ_W-1:0] sel_wdata_i,
  input  logic             en_we_i,
  input  logic             en_wbit_i,
  input  logic             sen_we_i,
  input  logic             sen_wbit_i,
  input  logic             end_we_i,
  input  logic             end_wbit_i,
  input  logic             stp_we_i,
  input  logic             stp_wbit_i,
  input  logic             irq_valid_i,
  input  logic [IRQ_W-1:0] irq_num_i,
  input  logic             stop_req_i,
  input  logic [IRQ_W-1:0] stop_src_i,
  input  logic             done_i,
  output logic             elig_o,
  output logic             en_o,
  output logic             end_o,
  output logic             stp_o
);
  logic [IRQ_W-1:0] sel_q;
  logic             en_q, sen_q, end_q, stp_q;
  logic             armed, stop_hit, end_set;

  assign armed    = en_q && !end_q;
  assign elig_o   = irq_valid_i && (irq_num_i == sel_q) && armed;
  assign stop_hit = stop_req_i && (stop_src_i == sel_q) && armed && sen_q;
  assign end_set  = done_i || stop_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      sen_q <= 1'b0;
      end_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      if (sel_we_i) sel_q <= sel_wdata_i;
      if (en_we_i)  en_q  <= en_wbit_i;
      if (sen_we_i) sen_q <= sen_wbit_i;
      // hardware set wins over software clear
      if (end_set)                      end_q <= 1'b1;
      else if (end_we_i && !end_wbit_i) end_q <= 1'b0;
      if (stop_hit)                     stp_q <= 1'b1;
      else if (stp_we_i && !stp_wbit_i) stp_q <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign end_o = end_q;
  assign stp_o = stp_q;
endmodule

// File: rtl/dma_disp_pick.sv
`timescale 1ns/1ps
module dma_disp_pick #(
  parameter int unsigned N   = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma_irq_dispatch.sv
`timescale 1ns/1ps
module dma_irq_dispatch
  import dma_disp_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned IRQ_W  = IRQ_W_DEF,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_reg_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [NUM_CH-1:0] cfg_wdata_i,
  input  logic              irq_valid_i,
  input  logic [IRQ_W-1:0]  irq_num_i,
  input  logic              stop_req_i,
  input  logic [IRQ_W-1:0]  stop_src_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic              start_o,
  output logic [CH_W-1:0]   start_ch_o,
  output logic              cpu_irq_o,
  output logic [IRQ_W-1:0]  cpu_irq_num_o,
  output logic [NUM_CH-1:0] end_flags_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic [NUM_CH-1:0] stop_flags_o
);
  cfg_reg_e          reg_sel;
  logic              en_we, sen_we, end_we, stp_we, sel_wr;
  logic [NUM_CH-1:0] elig;
  logic              any_elig;
  logic [CH_W-1:0]   win_ch;

  assign reg_sel = cfg_reg_e'(cfg_reg_i);
  assign en_we   = cfg_we_i && (reg_sel == REG_EN);
  assign end_we  = cfg_we_i && (reg_sel == REG_END);
  assign stp_we  = cfg_we_i && (reg_sel == REG_STP);
  assign sen_we  = cfg_we_i && (reg_sel == REG_SEN);
  assign sel_wr  = cfg_we_i && (reg_sel == REG_SEL);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dma_disp_chan #(.IRQ_W(IRQ_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_we_i    (sel_wr && (cfg_ch_i == CH_W'(n))),
      .sel_wdata_i (cfg_wdata_i[IRQ_W-1:0]),
      .en_we_i     (en_we),
      .en_wbit_i   (cfg_wdata_i[n]),
      .sen_we_i    (sen_we),
      .sen_wbit_i  (cfg_wdata_i[n]),
      .end_we_i    (end_we),
      .end_wbit_i  (cfg_wdata_i[n]),
      .stp_we_i    (stp_we),
      .stp_wbit_i  (cfg_wdata_i[n]),
      .irq_valid_i (irq_valid_i),
      .irq_num_i   (irq_num_i),
      .stop_req_i  (stop_req_i),
      .stop_src_i  (stop_src_i),
      .done_i      (done_i[n]),
      .elig_o      (elig[n]),
      .en_o        (enable_o[n]),
      .end_o       (end_flags_o[n]),
      .stp_o       (stop_flags_o[n])
    );
  end

  dma_disp_pick #(.N(NUM_CH)) u_pick (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (win_ch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o       <= 1'b0;
      start_ch_o    <= '0;
      cpu_irq_o     <= 1'b0;
      cpu_irq_num_o <= '0;
    end else begin
      start_o   <= any_elig;
      cpu_irq_o <= irq_valid_i && !any_elig;
      if (any_elig) start_ch_o <= win_ch;
      if (irq_valid_i && !any_elig) cpu_irq_num_o <= irq_num_i;
    end
  end
endmodule

// File: rtl/dma_irq_dispatch_chk.sv
`timescale 1ns/1ps
module dma_irq_dispatch_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned IRQ_W  = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_valid_i,
  input logic              stop_req_i,
  input logic [NUM_CH-1:0] done_i,
  input logic              start_o,
  input logic [CH_W-1:0]   start_ch_o,
  input logic              cpu_irq_o,
  input logic [NUM_CH-1:0] end_flags_o,
  input logic [NUM_CH-1:0] enable_o,
  input logic [NUM_CH-1:0] stop_flags_o
);
  logic [NUM_CH-1:0] armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= '0;
    else         armed_q <= enable_o & ~end_flags_o;
  end

  p_one_outcome_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && cpu_irq_o));

  p_valid_answered_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i |=> (start_o || cpu_irq_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_i |=> (!start_o && !cpu_irq_o));

  p_start_armed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> armed_q[start_ch_o]);

  p_done_sets_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((end_flags_o & $past(done_i)) == $past(done_i)));

  p_stop_sets_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stop_flags_o & ~$past(stop_flags_o)) != '0) |->
      ((end_flags_o & stop_flags_o & ~$past(stop_flags_o)) == (stop_flags_o & ~$past(stop_flags_o))));

  p_end_rise_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((end_flags_o & ~$past(end_flags_o) & ~$past(done_i)) != '0) |-> $past(stop_req_i));
endmodule

bind dma_irq_dispatch dma_irq_dispatch_chk #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/dma_irq_dispatch_tb.sv
`timescale 1ns/1ps
module dma_irq_dispatch_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_reg_i = '0;
  logic [3:0]  cfg_ch_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        irq_valid_i = 1'b0;
  logic [7:0]  irq_num_i = '0;
  logic        stop_req_i = 1'b0;
  logic [7:0]  stop_src_i = '0;
  logic [15:0] done_i = '0;
  logic        start_o, cpu_irq_o;
  logic [3:0]  start_ch_o;
  logic [7:0]  cpu_irq_num_o;
  logic [15:0] end_flags_o, enable_o, stop_flags_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_sel [16];
  logic [15:0] m_en = '0, m_sen = '0, m_end = '0, m_stp = '0;

  always #10 clk_i = ~clk_i;

  dma_irq_dispatch u_dut (.*);

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] elig_vec(input logic v, input logic [7:0] num);
    logic [15:0] e;
    for (int n = 0; n < 16; n++) e[n] = v && (m_sel[n] == num) && m_en[n] && !m_end[n];
    return e;
  endfunction

  function automatic logic [3:0] lowest(input logic [15:0] e);
    for (int n = 0; n < 16; n++) if (e[n]) return 4'(n);
    return 4'd0;
  endfunction

  task automatic step(input string tag, input logic v, input logic [7:0] num,
                      input logic sr, input logic [7:0] ss, input logic [15:0] dn,
                      input logic we, input logic [2:0] rg, input logic [3:0] ch,
                      input logic [15:0] wd);
    logic [15:0] e, hit, setv;
    logic exp_start, exp_cpu;
    logic [3:0] exp_ch;
    irq_valid_i = v; irq_num_i = num; stop_req_i = sr; stop_src_i = ss;
    done_i = dn; cfg_we_i = we; cfg_reg_i = rg; cfg_ch_i = ch; cfg_wdata_i = wd;
    e = elig_vec(v, num);
    exp_start = |e; exp_ch = lowest(e); exp_cpu = v && !(|e);
    for (int n = 0; n < 16; n++)
      hit[n] = sr && (m_sel[n] == ss) && m_en[n] && !m_end[n] && m_sen[n];
    @(posedge clk_i);
    #2;
    setv = dn | hit;
    m_end = setv | ((we && rg == 3'd1) ? (m_end & wd) : m_end);
    m_stp = hit  | ((we && rg == 3'd2) ? (m_stp & wd) : m_stp);
    if (we && rg == 3'd0) m_en = wd;
    if (we && rg == 3'd3) m_sen = wd;
    if (we && rg == 3'd4) m_sel[ch] = wd[7:0];
    irq_valid_i = 1'b0; stop_req_i = 1'b0; done_i = '0; cfg_we_i = 1'b0;
    chk(tag, "start_o", 16'(start_o), 16'(exp_start));
    if (exp_start) chk(tag, "start_ch_o", 16'(start_ch_o), 16'(exp_ch));
    chk(tag, "cpu_irq_o", 16'(cpu_irq_o), 16'(exp_cpu));
    if (exp_cpu) chk(tag, "cpu_irq_num_o", 16'(cpu_irq_num_o), 16'(num));
    chk(tag, "end_flags_o", end_flags_o, m_end);
    chk(tag, "stop_flags_o", stop_flags_o, m_stp);
    chk(tag, "enable_o", enable_o, m_en);
  endtask

  task automatic wr(input string tag, input logic [2:0] rg, input logic [3:0] ch, input logic [15:0] wd);
    step(tag, 1'b0, 8'h0, 1'b0, 8'h0, 16'h0, 1'b1, rg, ch, wd);
  endtask

  task automatic req(input string tag, input logic [7:0] num);
    step(tag, 1'b1, num, 1'b0, 8'h0, 16'h0, 1'b0, 3'd0, 4'd0, 16'h0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 16; n++) m_sel[n] = 8'h00;
    void'($urandom(32'd4242));
    #45 rst_ni = 1'b1;
    #6;
    // R1: reset state
    chk("R1", "start_o", 16'(start_o), 16'h0);
    chk("R1", "cpu_irq_o", 16'(cpu_irq_o), 16'h0);
    chk("R1", "end_flags_o", end_flags_o, 16'h0);
    chk("R1", "stop_flags_o", stop_flags_o, 16'h0);
    chk("R1", "enable_o", enable_o, 16'h0);

    wr("cfg", 3'd4, 4'd3, 16'h0020);
    wr("cfg", 3'd4, 4'd5, 16'h0020);
    wr("cfg", 3'd4, 4'd7, 16'h0030);
    wr("cfg", 3'd0, 4'd0, 16'h00A0);
    wr("cfg", 3'd3, 4'd0, 16'h0080);
    req("R2", 8'h20);                // ch3 disabled, ch5 starts
    req("R3", 8'h44);                // no match -> CPU
    wr("cfg", 3'd0, 4'd0, 16'h00A8);
    req("R5", 8'h20);                // ch3 and ch5 both eligible -> ch3
    step("R6", 1'b0, 8'h0, 1'b0, 8'h0, 16'h0008, 1'b0, 3'd0, 4'd0, 16'h0);
    req("R4", 8'h20);                // ch3 finished -> ch5
    step("R6", 1'b0, 8'h0, 1'b0, 8'h0, 16'h0020, 1'b0, 3'd0, 4'd0, 16'h0);
    req("R4", 8'h20);                // both finished -> CPU
    wr("R7", 3'd1, 4'd0, 16'hFFF7);  // clears bit3 only
    req("R10", 8'h20);               // ch3 re-armed
    // R8: stop on ch7 with stop-enable set
    step("R8", 1'b0, 8'h0, 1'b1, 8'h30, 16'h0, 1'b0, 3'd0, 4'd0, 16'h0);
    // R8: stop on 0x20 channels with stop-enable clear -> no change
    wr("R7", 3'd1, 4'd0, 16'h0000);
    step("R8", 1'b0, 8'h0, 1'b1, 8'h20, 16'h0, 1'b0, 3'd0, 4'd0, 16'h0);
    req("R3", 8'h30);                // ch7 end cleared, enabled -> starts
    wr("cfg", 3'd0, 4'd0, 16'h0028); // disable ch7
    req("R3", 8'h30);                // disabled -> CPU
    // R9: set and clear in same cycle
    step("R9", 1'b0, 8'h0, 1'b0, 8'h0, 16'h0020, 1'b1, 3'd1, 4'd0, 16'h0000);
    wr("R7", 3'd2, 4'd0, 16'h0000);  // clear stop flags
    wr("cfg", 3'd0, 4'd0, 16'h00A8);
    wr("R7", 3'd1, 4'd0, 16'h0000);
    step("R9", 1'b0, 8'h0, 1'b1, 8'h30, 16'h0, 1'b1, 3'd2, 4'd0, 16'h0000);
    // R11: idle cycle produces no outcome
    step("R11", 1'b0, 8'h20, 1'b0, 8'h0, 16'h0, 1'b0, 3'd0, 4'd0, 16'h0);

    // random phase: selectors in a narrow range to force sharing
    for (int n = 0; n < 16; n++) wr("cfg", 3'd4, 4'(n), 16'h0020 + 16'($urandom_range(0, 3)));
    wr("cfg", 3'd3, 4'd0, 16'($urandom));
    wr("cfg", 3'd0, 4'd0, 16'hFFFF);
    for (int k = 0; k < 600; k++) begin
      logic v, sr, we;
      logic [15:0] dn;
      logic [2:0] rg;
      v  = ($urandom_range(0, 3) != 0);
      sr = ($urandom_range(0, 7) == 0);
      dn = ($urandom_range(0, 3) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
      we = ($urandom_range(0, 4) == 0);
      rg = 3'($urandom_range(0, 3));
      step("R2/R5/R9 random", v, 8'h20 + 8'($urandom_range(0, 4)), sr,
           8'h20 + 8'($urandom_range(0, 3)), dn, we, rg, 4'd0, 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule